// File: doc/BRIEF.md
# Interrupt Pin Dispatch Core

This block is the dispatch engine of an I/O interrupt controller. Each input pin keeps a signed count of how many sources currently drive it. Sources change the count with assert, deassert and pulse commands. A pin is not sampled as a level. It wants service only on the step of its count from zero to one. The engine has one configuration entry for each pin, and it keeps a remote-IRR flag for every level-triggered pin. Each delivery attempt that survives the mask and the remote-IRR check becomes a pending request. Pending requests leave one at a time as interrupt messages on a valid/ready output.

End-of-interrupt (EOI) commands carry a vector number. An EOI releases every level pin that is waiting on that vector, and it re-delivers from any such pin that is still driven. A configuration write loads a whole entry in one strobe. After that write, a level pin that is still driven tries to deliver again. Commands naming a pin beyond the implemented range are refused with an error pulse.

Top module: `irq_dispatch_core`

## Requirements
- R1: After reset every entry is masked and edge-triggered with vector 0, every count is zero, no remote-IRR is set, `msg_valid` is low, and both error outputs are low.
- R2: An assert command (`cmd_op` = 0) adds one to the pin's count. A delivery attempt happens only when the count moves from 0 to 1. An assert from any other value, including -1 to 0, produces no message.
- R3: A deassert command (`cmd_op` = 1) subtracts one from the count and never produces a message. A pulse (`cmd_op` = 2) acts as an assert followed by a deassert, so the count is unchanged. Code 3 does nothing. `err_neg` pulses one cycle after any command whose result, or whose intermediate step, is below zero.
- R4: A delivery attempt on a masked pin is discarded. Unmasking the pin later does not bring it back.
- R5: On a level-triggered pin, an attempt is suppressed while remote-IRR is set. An accepted attempt sets remote-IRR.
- R6: An EOI with vector v clears remote-IRR on every pin that has remote-IRR set and is programmed with vector v. Each of those pins whose count is above zero attempts delivery again at once.
- R7: A configuration write that leaves a pin edge-triggered clears its remote-IRR. A write that leaves a pin level-triggered with a count above zero makes a delivery attempt.
- R8: A message carries the pin entry's vector, destination, logical-destination flag and delivery mode, together with a level flag equal to the pin's trigger mode.
- R9: A command whose pin number is NUM_PINS or more makes `err_pin` pulse on the next cycle and changes no count. A command with a pin in range never raises `err_pin`.
- R10: At most one request is pending per pin. When the output is free, the lowest-numbered pending pin is sent. While `msg_valid` is high and `msg_ready` is low, the message stays valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Pin command strobe |
| cmd_op | input | 2 | 0 assert, 1 deassert, 2 pulse, 3 no operation |
| cmd_pin | input | PIN_IN_W | Pin addressed by the command |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being acknowledged |
| cfg_we | input | 1 | Entry write strobe |
| cfg_pin | input | PIN_IN_W | Entry being written |
| cfg_mask | input | 1 | 1 masks the pin |
| cfg_level | input | 1 | 1 level-triggered, 0 edge-triggered |
| cfg_logical | input | 1 | 1 logical destination, 0 physical |
| cfg_dmode | input | 3 | Delivery mode |
| cfg_vector | input | 8 | Interrupt vector |
| cfg_dest | input | 8 | Destination identifier |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer takes the message |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 8 | Message destination |
| msg_logical | output | 1 | Message destination mode |
| msg_dmode | output | 3 | Message delivery mode |
| msg_level | output | 1 | Message came from a level-triggered pin |
| err_pin | output | 1 | One-cycle pulse: command pin out of range |
| err_neg | output | 1 | One-cycle pulse: count went below zero |

## Verification
The bench builds the core with NUM_PINS = 8 and PIN_IN_W = 4. With these values every pin can be swept through the whole assert, deassert and pulse ladder. The ladder runs through counts -1, 0, 1 and 2, both masked and unmasked. Half of the 4-bit pin space lies out of range, so every illegal pin number is tried with every operation. Out-of-range numbers alias onto real pins when truncated, so any wrong pin decode produces a stray message. With eight pins, a burst on all of them shows the whole ascending drain order.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;

    localparam int VEC_W   = 8;
    localparam int DEST_W  = 8;
    localparam int DMODE_W = 3;

    typedef enum logic [1:0] {
        OP_ASSERT   = 2'd0,
        OP_DEASSERT = 2'd1,
        OP_PULSE    = 2'd2,
        OP_NONE     = 2'd3
    } pin_op_e;

    typedef struct packed {
        logic               mask;
        logic               level;
        logic               logical;
        logic [DMODE_W-1:0] dmode;
        logic [VEC_W-1:0]   vector;
        logic [DEST_W-1:0]  dest;
    } irq_entry_t;

    typedef struct packed {
        logic [VEC_W-1:0]   vector;
        logic [DEST_W-1:0]  dest;
        logic               logical;
        logic [DMODE_W-1:0] dmode;
        logic               level;
    } irq_msg_t;

    localparam irq_entry_t ENTRY_RESET = '{mask: 1'b1, level: 1'b0, logical: 1'b0,
                                           dmode: '0, vector: '0, dest: '0};

endpackage

// File: rtl/irq_pin_slot.sv
module irq_pin_slot
    import irq_dispatch_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_hit,
    input  logic [1:0]             cmd_op,
    input  logic                   eoi_valid,
    input  logic [VEC_W-1:0]       eoi_vector,
    input  logic                   cfg_hit,
    input  irq_entry_t             cfg_entry,
    input  logic                   grant,
    output logic                   pend_o,
    output irq_entry_t             entry_o,
    output logic                   neg_o
);

    localparam logic signed [CNT_W-1:0] C_ZERO  = '0;
    localparam logic signed [CNT_W-1:0] C_ONE   = CNT_W'(1);
    localparam logic signed [CNT_W-1:0] C_M_ONE = -CNT_W'(1);

    typedef struct packed {
        irq_entry_t              ent;
        logic signed [CNT_W-1:0] cnt;
        logic                    rirr;
        logic                    pend;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  trig;
    logic  rirr_eff;
    logic  accept;
    logic  neg;

    always_comb begin
        slot_d   = slot_q;
        trig     = 1'b0;
        neg      = 1'b0;
        rirr_eff = slot_q.rirr;

        // entry write
        if (cfg_hit) begin
            slot_d.ent = cfg_entry;
            if (!cfg_entry.level) begin
                rirr_eff = 1'b0;
            end else if (slot_q.cnt > C_ZERO) begin
                trig = 1'b1;
            end
        end

        // end of interrupt on matching vector
        if (eoi_valid && slot_q.rirr && (slot_q.ent.vector == eoi_vector)) begin
            rirr_eff = 1'b0;
            if (slot_q.cnt > C_ZERO) begin
                trig = 1'b1;
            end
        end

        // pin command
        if (cmd_hit) begin
            unique case (pin_op_e'(cmd_op))
                OP_ASSERT: begin
                    slot_d.cnt = slot_q.cnt + C_ONE;
                    if (slot_q.cnt == C_ZERO) trig = 1'b1;
                    if (slot_q.cnt < C_M_ONE) neg = 1'b1;
                end
                OP_DEASSERT: begin
                    slot_d.cnt = slot_q.cnt - C_ONE;
                    if (slot_q.cnt <= C_ZERO) neg = 1'b1;
                end
                OP_PULSE: begin
                    if (slot_q.cnt == C_ZERO) trig = 1'b1;
                    if (slot_q.cnt < C_ZERO) neg = 1'b1;
                end
                default: begin
                end
            endcase
        end

        accept = trig && !slot_d.ent.mask && !(slot_d.ent.level && rirr_eff);

        slot_d.rirr = rirr_eff | (accept & slot_d.ent.level);
        slot_d.pend = (slot_q.pend & ~grant) | accept;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q.ent  <= ENTRY_RESET;
            slot_q.cnt  <= C_ZERO;
            slot_q.rirr <= 1'b0;
            slot_q.pend <= 1'b0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign pend_o  = slot_q.pend;
    assign entry_o = slot_q.ent;
    assign neg_o   = neg;

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int N     = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    always_comb begin
        gnt = req & (~req + {{(N-1){1'b0}}, 1'b1});
        any = |req;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/irq_dispatch_core.sv
module irq_dispatch_core
    import irq_dispatch_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int PIN_IN_W = 8,
    parameter int CNT_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic [PIN_IN_W-1:0] cmd_pin,
    input  logic                eoi_valid,
    input  logic [7:0]          eoi_vector,
    input  logic                cfg_we,
    input  logic [PIN_IN_W-1:0] cfg_pin,
    input  logic                cfg_mask,
    input  logic                cfg_level,
    input  logic                cfg_logical,
    input  logic [2:0]          cfg_dmode,
    input  logic [7:0]          cfg_vector,
    input  logic [7:0]          cfg_dest,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [7:0]          msg_vector,
    output logic [7:0]          msg_dest,
    output logic                msg_logical,
    output logic [2:0]          msg_dmode,
    output logic                msg_level,
    output logic                err_pin,
    output logic                err_neg
);

    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam logic [PIN_IN_W:0] PIN_LIMIT = (PIN_IN_W+1)'(NUM_PINS);

    typedef struct packed {
        logic     valid;
        irq_msg_t msg;
        logic     err_pin;
        logic     err_neg;
    } out_t;

    out_t out_d, out_q;

    irq_entry_t              cfg_entry;
    irq_entry_t              entries [NUM_PINS];
    logic [NUM_PINS-1:0]     pend;
    logic [NUM_PINS-1:0]     neg_vec;
    logic [NUM_PINS-1:0]     pick_gnt;
    logic [NUM_PINS-1:0]     grant;
    logic [IDX_W-1:0]        pick_idx;
    logic                    pick_any;
    logic                    load;

    always_comb begin
        cfg_entry.mask    = cfg_mask;
        cfg_entry.level   = cfg_level;
        cfg_entry.logical = cfg_logical;
        cfg_entry.dmode   = cfg_dmode;
        cfg_entry.vector  = cfg_vector;
        cfg_entry.dest    = cfg_dest;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_slot
        irq_pin_slot #(.CNT_W(CNT_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmd_hit    (cmd_valid && (cmd_pin == PIN_IN_W'(p))),
            .cmd_op     (cmd_op),
            .eoi_valid  (eoi_valid),
            .eoi_vector (eoi_vector),
            .cfg_hit    (cfg_we && (cfg_pin == PIN_IN_W'(p))),
            .cfg_entry  (cfg_entry),
            .grant      (grant[p]),
            .pend_o     (pend[p]),
            .entry_o    (entries[p]),
            .neg_o      (neg_vec[p])
        );
    end

    irq_lowest_pick #(.N(NUM_PINS)) u_pick (
        .req (pend),
        .gnt (pick_gnt),
        .idx (pick_idx),
        .any (pick_any)
    );

    always_comb begin
        out_d = out_q;
        load  = (!out_q.valid || msg_ready) && pick_any;
        grant = load ? pick_gnt : '0;

        if (!out_q.valid || msg_ready) begin
            out_d.valid = pick_any;
            if (pick_any) begin
                out_d.msg.vector  = entries[pick_idx].vector;
                out_d.msg.dest    = entries[pick_idx].dest;
                out_d.msg.logical = entries[pick_idx].logical;
                out_d.msg.dmode   = entries[pick_idx].dmode;
                out_d.msg.level   = entries[pick_idx].level;
            end
        end

        out_d.err_pin = cmd_valid && ({1'b0, cmd_pin} >= PIN_LIMIT);
        out_d.err_neg = |neg_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign msg_valid   = out_q.valid;
    assign msg_vector  = out_q.msg.vector;
    assign msg_dest    = out_q.msg.dest;
    assign msg_logical = out_q.msg.logical;
    assign msg_dmode   = out_q.msg.dmode;
    assign msg_level   = out_q.msg.level;
    assign err_pin     = out_q.err_pin;
    assign err_neg     = out_q.err_neg;

endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
    parameter int NUM_PINS = 32,
    parameter int PIN_IN_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic [PIN_IN_W-1:0] cmd_pin,
    input logic                msg_valid,
    input logic                msg_ready,
    input logic [7:0]          msg_vector,
    input logic [7:0]          msg_dest,
    input logic                msg_logical,
    input logic [2:0]          msg_dmode,
    input logic                msg_level,
    input logic                err_pin,
    input logic                err_neg
);

    localparam logic [PIN_IN_W:0] LIMIT = (PIN_IN_W+1)'(NUM_PINS);

    logic bad_cmd;
    assign bad_cmd = cmd_valid && ({1'b0, cmd_pin} >= LIMIT);

    // R10
    hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid);

    // R10
    hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> $stable(msg_vector) && $stable(msg_dest)
            && $stable(msg_logical) && $stable(msg_dmode) && $stable(msg_level));

    // R9
    bad_pin_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cmd |=> err_pin);

    // R9
    good_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_cmd |=> !err_pin);

    // R3
    err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pin |-> !err_neg);

endmodule

bind irq_dispatch_core irq_dispatch_chk #(.NUM_PINS(NUM_PINS), .PIN_IN_W(PIN_IN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_pin     (cmd_pin),
    .msg_valid   (msg_valid),
    .msg_ready   (msg_ready),
    .msg_vector  (msg_vector),
    .msg_dest    (msg_dest),
    .msg_logical (msg_logical),
    .msg_dmode   (msg_dmode),
    .msg_level   (msg_level),
    .err_pin     (err_pin),
    .err_neg     (err_neg)
);

// File: tb/tb_irq_dispatch_core.sv
`timescale 1ns/1ps
module tb_irq_dispatch_core;

    localparam int NP = 8;
    localparam int PW = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [PW-1:0] cmd_pin = '0;
    logic       eoi_valid = 1'b0;
    logic [7:0] eoi_vector = '0;
    logic       cfg_we = 1'b0;
    logic [PW-1:0] cfg_pin = '0;
    logic       cfg_mask = 1'b0, cfg_level = 1'b0, cfg_logical = 1'b0;
    logic [2:0] cfg_dmode = '0;
    logic [7:0] cfg_vector = '0, cfg_dest = '0;
    logic       msg_valid, msg_ready = 1'b0;
    logic [7:0] msg_vector, msg_dest;
    logic       msg_logical, msg_level;
    logic [2:0] msg_dmode;
    logic       err_pin, err_neg;

    int tests = 0;
    int fails = 0;
    int cnt_m [NP];
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_dispatch_core #(.NUM_PINS(NP), .PIN_IN_W(PW), .CNT_W(6)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_pin(cmd_pin),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .cfg_we(cfg_we), .cfg_pin(cfg_pin),
        .cfg_mask(cfg_mask), .cfg_level(cfg_level), .cfg_logical(cfg_logical),
        .cfg_dmode(cfg_dmode), .cfg_vector(cfg_vector), .cfg_dest(cfg_dest),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
        .msg_dest(msg_dest), .msg_logical(msg_logical), .msg_dmode(msg_dmode),
        .msg_level(msg_level), .err_pin(err_pin), .err_neg(err_neg));

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int pvec(int p);  return 8'h20 + p; endfunction
    function automatic int pdest(int p); return p * 3 + 1; endfunction

    task automatic cfg(int p, bit m, bit lv, int vec);
        cfg_we = 1'b1; cfg_pin = PW'(p); cfg_mask = m; cfg_level = lv;
        cfg_logical = p[0]; cfg_dmode = 3'(p); cfg_vector = 8'(vec); cfg_dest = 8'(pdest(p));
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // sends a command and checks both error pulses against the model
    task automatic send(string tag, int p, int op);
        int en = 0;
        int ep = (p >= NP) ? 1 : 0;
        if (p < NP) begin
            if (op == 0) begin en = (cnt_m[p] < -1); cnt_m[p]++; end
            if (op == 1) begin en = (cnt_m[p] <= 0); cnt_m[p]--; end
            if (op == 2) en = (cnt_m[p] < 0);
        end
        cmd_valid = 1'b1; cmd_pin = PW'(p); cmd_op = 2'(op);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk({tag, " err_neg"}, int'(err_neg), en);
        chk({tag, " err_pin"}, int'(err_pin), ep);
    endtask

    task automatic eoi(int v);
        eoi_valid = 1'b1; eoi_vector = 8'(v);
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic expect_msg(string tag, int p, int vec, bit lv);
        @(negedge clk);
        chk({tag, " valid"}, int'(msg_valid), 1);
        chk({tag, " fields"}, int'({msg_vector, msg_dest, msg_logical, msg_dmode, msg_level}),
            int'({8'(vec), 8'(pdest(p)), p[0], 3'(p), lv}));
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic expect_none(string tag);
        @(negedge clk);
        @(negedge clk);
        chk({tag, " no message"}, int'(msg_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < NP; p++) cnt_m[p] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 msg_valid", int'(msg_valid), 0);
        chk("R1 err_pin", int'(err_pin), 0);
        chk("R1 err_neg", int'(err_neg), 0);

        // R4 masked pins after reset drop everything; unmasking as edge stays quiet
        for (int p = 0; p < NP; p++) begin
            send("R1_R4 masked assert", p, 0);
            send("R4 masked pulse", p, 2);
            expect_none("R4 masked pin");
            cfg(p, 1'b0, 1'b0, pvec(p));
            expect_none("R4 unmask after drop");
            send("R3 deassert", p, 1);
        end

        // R2 R3 R8 count ladder on every unmasked edge pin
        for (int p = 0; p < NP; p++) begin
            send("R2 assert 0->1", p, 0);
            expect_msg("R2_R8 first assert", p, pvec(p), 1'b0);
            send("R2 assert 1->2", p, 0);
            expect_none("R2 second assert");
            send("R3 deassert 2->1", p, 1);
            send("R3 deassert 1->0", p, 1);
            expect_none("R3 deassert");
            send("R3 deassert 0->-1", p, 1);
            send("R3 pulse at -1", p, 2);
            send("R2 assert -1->0", p, 0);
            expect_none("R2 from negative");
            send("R3 pulse at 0", p, 2);
            expect_msg("R3 pulse delivers", p, pvec(p), 1'b0);
            send("R3 op3 no-op", p, 3);
            expect_none("R3 op3");
        end

        // R9 out-of-range pins, every op; aliases would deliver
        for (int p = NP; p < (1 << PW); p++) begin
            for (int op = 0; op < 3; op++) begin
                send("R9 bad pin", p, op);
            end
            expect_none("R9 no state change");
        end
        send("R9 good pin after bad", 0, 0);
        expect_msg("R9 counter untouched", 0, pvec(0), 1'b0);
        send("R9 restore", 0, 1);

        // R10 burst on all pins in descending order; held then drained ascending
        for (int p = NP - 1; p >= 0; p--) send("R10 burst", p, 0);
        repeat (3) @(negedge clk);
        chk("R10 held vector", int'(msg_vector), pvec(NP - 1));
        expect_msg("R10 first out", NP - 1, pvec(NP - 1), 1'b0);
        for (int p = 0; p < NP - 1; p++) expect_msg("R10 ascending", p, pvec(p), 1'b0);
        expect_none("R10 drained");
        for (int p = 0; p < NP; p++) send("R10 release", p, 1);

        // R5 R6 level pin 3
        cfg(3, 1'b0, 1'b1, 8'h43);
        send("R5 level assert", 3, 0);
        expect_msg("R5_R8 level msg", 3, 8'h43, 1'b1);
        send("R5 deassert", 3, 1);
        send("R5 reassert", 3, 0);
        expect_none("R5 blocked by remote-IRR");
        eoi(8'h44);
        expect_none("R6 other vector");
        eoi(8'h43);
        expect_msg("R6 redeliver", 3, 8'h43, 1'b1);
        send("R6 deassert", 3, 1);
        eoi(8'h43);
        expect_none("R6 count zero");
        send("R6 assert after clear", 3, 0);
        expect_msg("R6 cleared", 3, 8'h43, 1'b1);

        // R7 entry writes on pin 3 (count 1, remote-IRR set)
        cfg(3, 1'b0, 1'b1, 8'h43);
        expect_none("R7 rewrite blocked");
        cfg(3, 1'b0, 1'b0, 8'h43);
        expect_none("R7 edge write");
        cfg(3, 1'b0, 1'b1, 8'h43);
        expect_msg("R7 level write delivers", 3, 8'h43, 1'b1);
        cfg(3, 1'b0, 1'b0, 8'h43);
        cfg(3, 1'b1, 1'b1, 8'h43);
        expect_none("R4_R7 masked level write");
        cfg(3, 1'b0, 1'b1, 8'h43);
        expect_msg("R7 unmasked level write", 3, 8'h43, 1'b1);
        send("R7 cleanup", 3, 1);
        eoi(8'h43);

        // R6 shared vector on pins 2 and 5
        cfg(2, 1'b0, 1'b1, 8'h55);
        cfg(5, 1'b0, 1'b1, 8'h55);
        send("R6 pin5", 5, 0);
        expect_msg("R6 pin5 first", 5, 8'h55, 1'b1);
        send("R6 pin2", 2, 0);
        expect_msg("R6 pin2 first", 2, 8'h55, 1'b1);
        eoi(8'h55);
        expect_msg("R6_R10 pin2 again", 2, 8'h55, 1'b1);
        expect_msg("R6_R10 pin5 again", 5, 8'h55, 1'b1);
        expect_none("R6 done");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule